// File: doc/BRIEF.md
# TPM-style SPI Register Access Controller

This block is the controller end of a flow-controlled register-access protocol carried over SPI mode 0. A client issues one request through a start pulse. The request gives the direction, a byte count from 1 to 64 and a 24-bit register address. For a write, the block pulls payload bytes one at a time through a pop strobe. For a read, it hands back captured bytes one at a time with a valid strobe. The block drives the serial clock, MOSI and an active-low chip select, and it samples MISO.

A transaction always opens with a four-byte header: a command byte, then the address. The peripheral uses the last bit of the fourth received byte to grant the data phase or to hold it off. While held off, the controller keeps clocking idle bytes and looks at bit 0 of each one it receives. The first such byte with bit 0 set ends the hold, and payload moves on the next byte. If the hold outlasts a programmable number of idle bytes, the transaction is abandoned and flagged. Either way, chip select is raised and a one-cycle completion pulse follows.

The controller is a five-state machine:
- IDLE waits for `start` and goes to HEAD.
- HEAD sends the four header bytes. From HEAD it goes to DATA when the grant bit is set, to STALL when the grant bit is clear and `max_wait` is nonzero, or to CLOSE as a timeout when `max_wait` is zero.
- STALL sends idle bytes. It goes to DATA on a granted byte, or to CLOSE as a timeout once `max_wait` idle bytes have all come back clear.
- DATA moves the payload and goes to CLOSE after the last byte.
- CLOSE returns to IDLE and raises `done`.

Top module: `tpm_spi_xact`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, and `busy` and `done` are 0.
- R2: The first four bytes on MOSI are, in this order: the command byte, then address bits 23:16, 15:8 and 7:0. The command byte holds the direction in bit 7 (1 = read), a 0 in bit 6, and the byte count minus one in bits 5:0, so a 4-byte read is 0x83. Every byte is shifted out most significant bit first.
- R3: `sclk` idles low. Each high and each low half-period lasts `clk_div`+1 cycles of `clk`. MOSI is stable at every rising edge and MISO is sampled there.
- R4: Only bit 0 of the fourth received byte decides the grant; bit 0 of received bytes 1 to 3 has no effect. When that bit is 1, payload starts on the fifth byte.
- R5: When that bit is 0, the block sends 0x00 bytes. It starts payload on the byte right after the first received byte whose bit 0 is 1.
- R6: On a write, `wr_pop` pulses once per payload byte, exactly the requested count. The byte on `wr_data` at each pop is the byte sent next.
- R7: On a read, MOSI carries 0x00 during payload. `rd_valid` pulses once per received payload byte, in order, with the byte on `rd_data`.
- R8: Chip select falls once per transaction and stays low over header, idle bytes and payload. `sclk` is never high while `cs_n` is high.
- R9: When `max_wait` idle bytes all return bit 0 clear, the block stops after those bytes (4+`max_wait` bytes in total). It raises `timed_out` together with `done` and moves no payload. A hold of exactly `max_wait` idle bytes, the last one granted, still succeeds.
- R10: `done` is high for exactly one cycle, and that cycle is the one after `cs_n` rises.
- R11: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | 8 | Half-period length of `sclk` minus one, in `clk` cycles |
| max_wait | input | 8 | Largest number of idle bytes tolerated while held off |
| start | input | 1 | One-cycle request strobe |
| req_read | input | 1 | 1 = read, 0 = write |
| req_len_m1 | input | 6 | Byte count minus one |
| req_addr | input | 24 | Register address |
| wr_data | input | 8 | Next write payload byte |
| wr_pop | output | 1 | Payload byte on `wr_data` consumed this cycle |
| rd_data | output | 8 | Received payload byte |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | With `done`: hold-off limit exceeded |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Controller data out |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Peripheral data in |

## Verification
The assertions assume three things about the inputs. First, `clk_div` and `max_wait` stay constant while `busy` is high. Second, `wr_data` already holds the next byte whenever a pop can occur. Third, MISO changes only on falling edges of `sclk` or while chip select is high. The bench keeps to all three: it changes the settings only between transactions, serves `wr_data` from a table indexed by the pops seen so far, and models the peripheral so that it updates MISO only at chip-select assertion and on falling `sclk` edges. Grant bytes with other bits set, and early header bytes with bit 0 set, show that only the intended bit is decoded.

// File: rtl/tpm_spi_pkg.sv
package tpm_spi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_STALL,
        ST_DATA,
        ST_CLOSE
    } xact_state_e;

    localparam logic [7:0] FILL_BYTE = 8'h00;
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              active,
    output logic              word_done,
    output logic [WORD_W-1:0] rx_word
);
    localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] tx_sr;
    logic [WORD_W-1:0] rx_sr;
    logic [CNT_W-1:0]  bit_cnt;

    assign mosi    = tx_sr[WORD_W-1];
    assign rx_word = rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr     <= '0;
            rx_sr     <= '0;
            bit_cnt   <= '0;
            sclk      <= 1'b0;
            active    <= 1'b0;
            word_done <= 1'b0;
        end else begin
            word_done <= 1'b0;
            if (load) begin
                tx_sr   <= load_word;
                bit_cnt <= '0;
                sclk    <= 1'b0;
                active  <= 1'b1;
            end else if (active && tick) begin
                if (!sclk) begin
                    sclk  <= 1'b1;
                    rx_sr <= {rx_sr[WORD_W-2:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_cnt == LAST_BIT) begin
                        active    <= 1'b0;
                        word_done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        tx_sr   <= {tx_sr[WORD_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    // R3: the serial clock only moves on a divider tick
    p_sclk_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sclk));

    // R3: a finished word leaves the clock low
    p_word_ends_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> !sclk);
endmodule

// File: rtl/tpm_spi_xact.sv
module tpm_spi_xact #(
    parameter int DIV_W  = 8,
    parameter int WAIT_W = 8,
    parameter int LEN_W  = 6,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [WAIT_W-1:0] max_wait,
    input  logic              start,
    input  logic              req_read,
    input  logic [LEN_W-1:0]  req_len_m1,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        wr_data,
    output logic              wr_pop,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              done,
    output logic              timed_out,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    input  logic              miso
);
    import tpm_spi_pkg::*;

    localparam int HDR_N   = ADDR_W / 8 + 1;
    localparam int HIDX_W  = $clog2(HDR_N);
    localparam int IDX_W   = (LEN_W > HIDX_W) ? LEN_W : HIDX_W;
    localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(HDR_N - 1);

    xact_state_e       state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [WAIT_W-1:0] wait_q, wait_d;
    logic              kick_q, kick_d;
    logic              abort_q, abort_d;
    logic              rd_q;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] addr_q;

    logic              ld;
    logic [7:0]        ld_byte;
    logic              tick;
    logic              sh_active;
    logic              sh_done;
    logic [7:0]        sh_rx;
    logic [HDR_N*8-1:0] hdr_vec;

    assign hdr_vec = {rd_q, 1'b0, 6'(len_q), addr_q};
    assign busy    = (state_q != ST_IDLE);

    function automatic logic [7:0] hdr_byte(input logic [HDR_N*8-1:0] v,
                                            input logic [IDX_W-1:0] i);
        return v[8*(HDR_N-1-int'(i)) +: 8];
    endfunction

    spi_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (sh_active),
        .div  (clk_div),
        .tick (tick)
    );

    spi_byte_shift #(.WORD_W(8)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (ld),
        .load_word(ld_byte),
        .miso     (miso),
        .sclk     (sclk),
        .mosi     (mosi),
        .active   (sh_active),
        .word_done(sh_done),
        .rx_word  (sh_rx)
    );

    // next state and byte issue
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        wait_d  = wait_q;
        kick_d  = 1'b0;
        abort_d = abort_q;
        ld      = 1'b0;
        ld_byte = FILL_BYTE;
        wr_pop  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_HEAD;
                    idx_d   = '0;
                    kick_d  = 1'b1;
                    abort_d = 1'b0;
                end
            end
            ST_HEAD: begin
                if (kick_q) begin
                    ld      = 1'b1;
                    ld_byte = hdr_byte(hdr_vec, '0);
                end else if (sh_done) begin
                    if (idx_q != HDR_LAST) begin
                        idx_d   = idx_q + 1'b1;
                        ld      = 1'b1;
                        ld_byte = hdr_byte(hdr_vec, idx_q + 1'b1);
                    end else if (sh_rx[0]) begin
                        state_d = ST_DATA;
                        idx_d   = '0;
                        ld      = 1'b1;
                        ld_byte = rd_q ? FILL_BYTE : wr_data;
                        wr_pop  = !rd_q;
                    end else if (max_wait == '0) begin
                        state_d = ST_CLOSE;
                        abort_d = 1'b1;
                    end else begin
                        state_d = ST_STALL;
                        wait_d  = WAIT_W'(1);
                        ld      = 1'b1;
                    end
                end
            end
            ST_STALL: begin
                if (sh_done) begin
                    if (sh_rx[0]) begin
                        state_d = ST_DATA;
                        idx_d   = '0;
                        ld      = 1'b1;
                        ld_byte = rd_q ? FILL_BYTE : wr_data;
                        wr_pop  = !rd_q;
                    end else if (wait_q == max_wait) begin
                        state_d = ST_CLOSE;
                        abort_d = 1'b1;
                    end else begin
                        wait_d = wait_q + 1'b1;
                        ld     = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (sh_done) begin
                    if (idx_q == IDX_W'(len_q)) begin
                        state_d = ST_CLOSE;
                    end else begin
                        idx_d   = idx_q + 1'b1;
                        ld      = 1'b1;
                        ld_byte = rd_q ? FILL_BYTE : wr_data;
                        wr_pop  = !rd_q;
                    end
                end
            end
            ST_CLOSE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            wait_q  <= '0;
            kick_q  <= 1'b0;
            abort_q <= 1'b0;
            rd_q    <= 1'b0;
            len_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            wait_q  <= wait_d;
            kick_q  <= kick_d;
            abort_q <= abort_d;
            if (state_q == ST_IDLE && start) begin
                rd_q   <= req_read;
                len_q  <= req_len_m1;
                addr_q <= req_addr;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n      <= 1'b1;
            done      <= 1'b0;
            timed_out <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            if (state_q == ST_IDLE && state_d == ST_HEAD) begin
                cs_n <= 1'b0;
            end else if (state_d == ST_CLOSE) begin
                cs_n <= 1'b1;
            end
            done      <= (state_q == ST_CLOSE);
            timed_out <= (state_q == ST_CLOSE) && abort_q;
            rd_valid  <= (state_q == ST_DATA) && sh_done && rd_q;
            if ((state_q == ST_DATA) && sh_done && rd_q) begin
                rd_data <= sh_rx;
            end
        end
    end

    // R8: no clock edge outside a framed transaction
    p_sclk_framed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: completion follows a released chip select
    p_done_after_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(cs_n)));

    // R9: the timeout flag only travels with completion
    p_timeout_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timed_out |-> done);

    // R6: payload is only consumed inside the frame
    p_pop_framed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pop |-> !cs_n);
endmodule

// File: tb/tpm_spi_xact_test.sv
module tpm_spi_xact_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] clk_div = 8'd0;
    logic [7:0] max_wait = 8'd8;
    logic       start = 1'b0;
    logic       req_read = 1'b0;
    logic [5:0] req_len_m1 = 6'd0;
    logic [23:0] req_addr = 24'd0;
    logic [7:0] wr_data;
    logic       wr_pop, rd_valid, busy, done, timed_out, sclk, mosi, cs_n;
    logic [7:0] rd_data;
    logic       miso = 1'b0;

    int vectors = 0;
    int fails = 0;

    logic [7:0] wr_buf [64];
    int pops_total = 0;
    int pops_base = 0;
    assign wr_data = wr_buf[(pops_total - pops_base) & 63];

    always #(CLK_P/2) clk = ~clk;

    tpm_spi_xact uut (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .max_wait(max_wait),
        .start(start), .req_read(req_read), .req_len_m1(req_len_m1),
        .req_addr(req_addr), .wr_data(wr_data), .wr_pop(wr_pop),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
        .timed_out(timed_out), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .miso(miso)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // peripheral model
    logic [7:0] resp_q[$];
    logic [7:0] mosi_q[$];
    logic [7:0] cur_tx = 8'h00;
    logic [7:0] sh_in = 8'h00;
    int bitn = 0;
    int cs_falls = 0;

    function automatic logic [7:0] next_resp();
        if (resp_q.size() > 0) return resp_q.pop_front();
        return 8'h02;
    endfunction

    always @(negedge cs_n) begin
        if (rst_n) begin
            cs_falls++;
            bitn = 0;
            cur_tx = next_resp();
            miso = cur_tx[7];
        end
    end

    always @(posedge sclk) begin
        if (cs_n === 1'b0) sh_in = {sh_in[6:0], mosi};
    end

    always @(negedge sclk) begin
        if (cs_n === 1'b0) begin
            bitn++;
            if (bitn == 8) begin
                mosi_q.push_back(sh_in);
                bitn = 0;
                cur_tx = next_resp();
                miso = cur_tx[7];
            end else begin
                miso = cur_tx[7-bitn];
            end
        end
    end

    always @(posedge clk) if (rst_n && wr_pop) pops_total++;

    // per-clock reference comparisons
    logic [7:0] rd_got[$];
    logic p1 = 1'b1, p2 = 1'b1, sclk_prev = 1'b0;
    int hp_cnt = 0;
    int done_seen = 0;
    logic last_to = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            check(!(sclk && cs_n), "R8", "sclk high outside frame", sclk, 0);
            check(done == (cs_n && p1 && !p2), "R10", "done timing", done,
                  cs_n && p1 && !p2);
            if (sclk !== sclk_prev) begin
                if (!sclk) check(hp_cnt == int'(clk_div) + 1, "R3",
                                 "high half-period", hp_cnt, int'(clk_div) + 1);
                hp_cnt = 1;
            end else begin
                hp_cnt++;
            end
            sclk_prev = sclk;
            p2 = p1;
            p1 = cs_n;
            if (rd_valid) rd_got.push_back(rd_data);
            if (done) begin
                done_seen++;
                last_to = timed_out;
            end
        end
    end

    task automatic run(input bit rd, input int len, input logic [23:0] addr,
                       input int div, input int mw, input int nwait,
                       input bit exp_to, input bit poke);
        logic [7:0] rd_exp[$];
        int ds, cf, total, pops0;
        rd_exp = {};
        resp_q = {};
        mosi_q = {};
        rd_got = {};
        for (int i = 0; i < 64; i++) wr_buf[i] = 8'(i * 37 + len + 5);
        for (int i = 0; i < 3; i++) resp_q.push_back(8'h11);
        if (exp_to) begin
            for (int i = 0; i < mw + 3; i++) resp_q.push_back(8'hFE);
        end else begin
            if (nwait == 0) resp_q.push_back(8'h81);
            else begin
                resp_q.push_back(8'h3C);
                for (int i = 1; i < nwait; i++) resp_q.push_back(8'h3C);
                resp_q.push_back(8'hA5);
            end
            for (int i = 0; i < len; i++) begin
                rd_exp.push_back(8'(i * 29 + 8'h40 + len));
                resp_q.push_back(8'(i * 29 + 8'h40 + len));
            end
        end
        @(negedge clk);
        clk_div = 8'(div);
        max_wait = 8'(mw);
        req_read = rd;
        req_len_m1 = 6'(len - 1);
        req_addr = addr;
        pops_base = pops_total;
        pops0 = pops_total;
        ds = done_seen;
        cf = cs_falls;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (40) @(negedge clk);
            check(busy == 1'b1, "R11", "busy mid-transaction", busy, 1);
            req_read = !rd;
            req_len_m1 = 6'd9;
            req_addr = 24'h123456;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 60000 && done_seen == ds; t++) @(negedge clk);
        check(done_seen == ds + 1, "R10", "one done per transaction",
              done_seen - ds, 1);
        repeat (3) @(negedge clk);
        check(cs_falls == cf + 1, poke ? "R11" : "R8", "chip-select windows",
              cs_falls - cf, 1);
        check(last_to == exp_to, "R9", "timeout flag", last_to, exp_to);
        total = exp_to ? 4 + mw : 4 + nwait + len;
        check(mosi_q.size() == total, exp_to ? "R9" : "R8", "bytes in frame",
              mosi_q.size(), total);
        if (mosi_q.size() >= 4) begin
            check(mosi_q[0] == {rd, 1'b0, 6'(len - 1)}, "R2", "command byte",
                  mosi_q[0], {rd, 1'b0, 6'(len - 1)});
            check(mosi_q[1] == addr[23:16], "R2", "addr hi", mosi_q[1], addr[23:16]);
            check(mosi_q[2] == addr[15:8], "R2", "addr mid", mosi_q[2], addr[15:8]);
            check(mosi_q[3] == addr[7:0], "R2", "addr lo", mosi_q[3], addr[7:0]);
        end
        if (mosi_q.size() == total) begin
            for (int i = 4; i < total; i++) begin
                if (exp_to || i < 4 + nwait)
                    check(mosi_q[i] == 8'h00, nwait == 0 ? "R4" : "R5",
                          "idle byte", mosi_q[i], 0);
                else if (rd)
                    check(mosi_q[i] == 8'h00, "R7", "read fill byte", mosi_q[i], 0);
                else
                    check(mosi_q[i] == wr_buf[i - 4 - nwait], "R6", "write payload",
                          mosi_q[i], wr_buf[i - 4 - nwait]);
            end
        end
        check(pops_total - pops0 == ((rd || exp_to) ? 0 : len), "R6",
              "pop count", pops_total - pops0, (rd || exp_to) ? 0 : len);
        if (rd && !exp_to) begin
            check(rd_got.size() == len, "R7", "read byte count", rd_got.size(), len);
            for (int i = 0; i < len && i < rd_got.size(); i++)
                check(rd_got[i] == rd_exp[i], "R7", "read data", rd_got[i], rd_exp[i]);
        end else begin
            check(rd_got.size() == 0, exp_to ? "R9" : "R7", "no read strobes",
                  rd_got.size(), 0);
        end
    endtask

    initial begin
        #(CLK_P * 190000);
        fails++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", done_seen, -1);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 1'b1, "R1", "cs_n after reset", cs_n, 1);
        check(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(done == 1'b0, "R1", "done after reset", done, 0);
        run(0, 4, 24'hAABBCC, 0, 8, 0, 0, 0);   // R4 immediate grant, write
        run(0, 4, 24'hAABBCC, 3, 8, 3, 0, 0);   // R5 three idle bytes
        run(1, 4, 24'h0F1E2D, 1, 8, 3, 0, 0);   // R7 read after hold
        run(1, 1, 24'h000001, 0, 8, 0, 0, 0);   // R7 single byte
        run(0, 64, 24'hFFFFFF, 0, 8, 1, 0, 0);  // R6 largest write
        run(1, 2, 24'h800000, 7, 8, 0, 0, 0);   // R3 slow clock
        run(0, 3, 24'h4455AA, 0, 5, 5, 0, 0);   // R9 hold equals limit
        run(0, 3, 24'h4455AA, 2, 2, 0, 1, 0);   // R9 timeout
        run(1, 3, 24'h010203, 0, 0, 0, 1, 0);   // R9 zero limit
        run(0, 8, 24'h5A5A5A, 1, 8, 2, 0, 1);   // R11 start while busy
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule